// File: doc/BRIEF.md
# User-Mode Address Bounds Guard

This block sits between a processor's address output and the memory port. Each cycle it can take one address request together with the current privilege bit. When the processor runs in user mode, the block compares the address against a window held in two internal registers. One register holds the window start and the other holds the window size. A legal address is passed on with a grant. An illegal address is blocked and causes a one-cycle trap pulse. Kernel-mode requests skip the check and pass through unchanged.

A relocation mode is also available. In this mode a user address counts as an offset into the window: it is checked against the size and then added to the start register to form the physical address. The two registers are loaded through a small write port. The port accepts writes only while the privilege bit shows kernel mode. A write attempted from user mode changes nothing and raises the trap instead.

All results are registered. A request presented before a clock edge produces its grant, trap and physical address just after that edge.

Top module: `addr_guard`

## Requirements
- R1: After reset, grant, trap and phys_addr are 0, and both window registers are 0. A user access made right after reset therefore traps.
- R2: In user mode (priv_mode=1) with reloc_en=0, a request for address A is granted with phys_addr=A when base <= A < base+limit.
- R3: In user mode, a request outside the legal window gives trap=1, grant=0 and phys_addr=0 in the output cycle, so the address never reaches memory.
- R4: In kernel mode (priv_mode=0), every request is granted with phys_addr equal to the request address. This holds whatever the window holds and whatever reloc_en is.
- R5: In user mode with reloc_en=1, a request for offset A is legal when A < limit and A+base fits in ADDR_W bits. A legal request is granted with phys_addr=A+base; any other request traps.
- R6: A kernel-mode write with cfg_wr_en=1 loads cfg_wdata into the window start when cfg_sel=0 and into the window size when cfg_sel=1. A request in the same cycle still uses the old values; requests from the next cycle on use the new ones.
- R7: A write attempted in user mode leaves both registers unchanged. It gives trap=1 and grant=0 in the output cycle, and a request made in the same cycle is blocked.
- R8: The window end base+limit is formed with one extra carry bit. A window that runs past the top of the address space therefore does not wrap around: addresses below base still trap.
- R9: Outputs follow their inputs by exactly one clock. grant and trap are never both 1. A cycle with no request and no write gives grant=0 and trap=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Address request present |
| req_addr | input | ADDR_W | Logical address of the request |
| priv_mode | input | 1 | Privilege bit: 0 kernel, 1 user |
| reloc_en | input | 1 | User addresses are offsets added to the window start |
| cfg_wr_en | input | 1 | Window register write strobe |
| cfg_sel | input | 1 | Write target: 0 window start, 1 window size |
| cfg_wdata | input | ADDR_W | Value to write |
| grant | output | 1 | Registered: access allowed |
| trap | output | 1 | Registered: violation pulse |
| phys_addr | output | ADDR_W | Registered physical address, 0 when not granted |

## Verification
User requests are placed on both edges of a window: at the first and last legal addresses, one below the start and one past the end. These cases separate an inclusive end comparison from an exclusive one. Relocated offsets are tried at zero, at limit-1 and at limit. One offset whose sum carries out of the address width is also tried, which separates a correct carry test from a truncated sum. A window that runs past the top of the address space shows whether the end comparison wraps. Kernel requests and writes are mixed with user write attempts, and the registers are then probed through later accesses. This shows that privileged writes take effect one cycle later and that user writes change nothing.

// File: rtl/guard_pkg.sv
package guard_pkg;
    localparam logic PRIV_KERNEL = 1'b0;
    localparam logic PRIV_USER   = 1'b1;
    localparam logic SEL_BASE    = 1'b0;
    localparam logic SEL_LIMIT   = 1'b1;
endpackage

// File: rtl/guard_bounds_regs.sv
module guard_bounds_regs
    import guard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              priv,
    input  logic              sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] limit_q,
    output logic              denied
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d  = win_q;
        denied = wr_en && (priv == PRIV_USER);
        if (wr_en && (priv == PRIV_KERNEL)) begin
            if (sel == SEL_BASE) win_d.base  = wdata;
            else                 win_d.limit = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign base_q  = win_q.base;
    assign limit_q = win_q.limit;

    // R7: a user-mode write must not disturb either register
    assert_user_write_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && priv == PRIV_USER) |=> ($stable(base_q) && $stable(limit_q)));
endmodule

// File: rtl/guard_range_check.sv
module guard_range_check #(
    parameter int ADDR_W = 32
) (
    input  logic              reloc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    output logic              in_range,
    output logic [ADDR_W-1:0] xlat
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] win_end;
    logic [EXT_W-1:0] rel_sum;
    logic             abs_ok;
    logic             rel_ok;

    always_comb begin
        win_end  = {1'b0, base} + {1'b0, limit};
        rel_sum  = {1'b0, addr} + {1'b0, base};
        abs_ok   = (addr >= base) && ({1'b0, addr} < win_end);
        rel_ok   = (addr < limit) && !rel_sum[ADDR_W];
        in_range = reloc ? rel_ok : abs_ok;
        xlat     = reloc ? rel_sum[ADDR_W-1:0] : addr;
    end
endmodule

// File: rtl/addr_guard.sv
module addr_guard
    import guard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              priv_mode,
    input  logic              reloc_en,
    input  logic              cfg_wr_en,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              grant,
    output logic              trap,
    output logic [ADDR_W-1:0] phys_addr
);
    typedef struct packed {
        logic              grant;
        logic              trap;
        logic [ADDR_W-1:0] addr;
    } resp_t;

    logic [ADDR_W-1:0] base_w, limit_w, xlat_w;
    logic              in_range_w, wr_denied_w;
    resp_t             resp_d, resp_q;

    guard_bounds_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .priv    (priv_mode),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .base_q  (base_w),
        .limit_q (limit_w),
        .denied  (wr_denied_w)
    );

    guard_range_check #(.ADDR_W(ADDR_W)) u_check (
        .reloc    (reloc_en),
        .addr     (req_addr),
        .base     (base_w),
        .limit    (limit_w),
        .in_range (in_range_w),
        .xlat     (xlat_w)
    );

    always_comb begin
        logic user_req;
        logic bad_req;
        user_req     = req_valid && (priv_mode == PRIV_USER);
        bad_req      = user_req && !in_range_w;
        resp_d       = '0;
        resp_d.trap  = wr_denied_w || bad_req;
        resp_d.grant = req_valid && !resp_d.trap;
        if (resp_d.grant) resp_d.addr = user_req ? xlat_w : req_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign grant     = resp_q.grant;
    assign trap      = resp_q.trap;
    assign phys_addr = resp_q.addr;

    // R9: grant and trap never together
    assert_grant_trap_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && trap));

    // R9: an idle cycle produces neither response
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !cfg_wr_en) |=> (!grant && !trap));

    // R4: kernel requests pass through untouched
    assert_kernel_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && priv_mode == PRIV_KERNEL) |=> (grant && phys_addr == $past(req_addr)));

    // R3: user access below the window start traps
    assert_below_base_traps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && priv_mode == PRIV_USER && !reloc_en && req_addr < base_w)
        |=> (trap && phys_addr == '0));

    // R7: user-mode write attempt traps
    assert_user_cfg_traps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && priv_mode == PRIV_USER) |=> (trap && !grant));
endmodule

// File: tb/tb_addr_guard.sv
module tb_addr_guard;
    localparam int AW = 32;
    localparam longint SPACE = longint'(1) << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          priv_mode = 1'b0;
    logic          reloc_en = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          grant, trap;
    logic [AW-1:0] phys_addr;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    string  cur_tag = "R1";
    string  e_tag = "R1";
    bit     ready = 1'b0;
    bit     e_g, e_t;
    longint e_a;
    longint m_base, m_limit;
    longint a, ph;
    bit     ok, ucfg;

    always #2.5 clk = ~clk;

    addr_guard #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .priv_mode(priv_mode), .reloc_en(reloc_en), .cfg_wr_en(cfg_wr_en),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .grant(grant), .trap(trap), .phys_addr(phys_addr)
    );

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_base = 0; m_limit = 0;
            e_g = 0; e_t = 0; e_a = 0; e_tag = "R1";
        end else begin
            a = longint'(req_addr);
            if (!priv_mode) begin
                ok = 1; ph = a;
            end else if (reloc_en) begin
                ok = (a < m_limit) && (a + m_base < SPACE);
                ph = a + m_base;
            end else begin
                ok = (a >= m_base) && (a < m_base + m_limit);
                ph = a;
            end
            ucfg = cfg_wr_en && priv_mode;
            e_t = ucfg || (req_valid && priv_mode && !ok);
            e_g = req_valid && !e_t;
            e_a = e_g ? (ph % SPACE) : 0;
            if (cfg_wr_en && !priv_mode) begin
                if (!cfg_sel) m_base = longint'(cfg_wdata);
                else          m_limit = longint'(cfg_wdata);
            end
            e_tag = cur_tag;
        end
        ready = 1'b1;
    end

    always @(negedge clk) begin
        if (ready && !done) begin
            total++;
            if (grant !== e_g || trap !== e_t || longint'(phys_addr) != e_a) begin
                bad++;
                $display("FAIL %s: grant=%0b trap=%0b phys=%0h expected grant=%0b trap=%0b phys=%0h",
                         e_tag, grant, trap, phys_addr, e_g, e_t, e_a);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            total++; bad++;
            $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(input string tag, input bit rv, input longint ad, input bit pm,
                        input bit rl, input bit wr, input bit sl, input longint wd);
        @(negedge clk);
        cur_tag   = tag;
        req_valid = rv;
        req_addr  = AW'(ad);
        priv_mode = pm;
        reloc_en  = rl;
        cfg_wr_en = wr;
        cfg_sel   = sl;
        cfg_wdata = AW'(wd);
    endtask

    task automatic kwrite(input bit sl, input longint wd);
        step("R6", 0, 0, 0, 0, 1, sl, wd);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty window after reset
        step("R1", 1, 0, 1, 0, 0, 0, 0);
        // R6: program window 300040 / 120900
        kwrite(0, 300040);
        kwrite(1, 120900);
        // R2: legal user accesses, inclusive start and last
        step("R2", 1, 300040, 1, 0, 0, 0, 0);
        step("R2", 1, 420939, 1, 0, 0, 0, 0);
        step("R2", 1, 350000, 1, 0, 0, 0, 0);
        // R3: just past end and just below start
        step("R3", 1, 420940, 1, 0, 0, 0, 0);
        step("R3", 1, 300039, 1, 0, 0, 0, 0);
        idle("R9");
        // R4: kernel bypass, even with relocation flag
        step("R4", 1, 5, 0, 1, 0, 0, 0);
        step("R4", 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        // R5: relocation with base 14000, limit 1000
        kwrite(0, 14000);
        kwrite(1, 1000);
        step("R5", 1, 346, 1, 1, 0, 0, 0);
        step("R5", 1, 0, 1, 1, 0, 0, 0);
        step("R5", 1, 999, 1, 1, 0, 0, 0);
        step("R5", 1, 1000, 1, 1, 0, 0, 0);
        // R5: carry out of the relocated sum
        kwrite(0, 32'hFFFF_FF00);
        kwrite(1, 32'h0000_1000);
        step("R5", 1, 32'h100, 1, 1, 0, 0, 0);
        step("R5", 1, 32'hFF, 1, 1, 0, 0, 0);
        // R8: window crossing the top of the space
        kwrite(0, 32'hFFFF_FFF0);
        kwrite(1, 32'h40);
        step("R8", 1, 32'hFFFF_FFFF, 1, 0, 0, 0, 0);
        step("R8", 1, 32'h10, 1, 0, 0, 0, 0);
        step("R8", 1, 32'hFFFF_FFEF, 1, 0, 0, 0, 0);
        // R7: user write attempts leave the window intact
        step("R7", 0, 0, 1, 0, 1, 0, 0);
        step("R7", 1, 32'hFFFF_FFF5, 1, 0, 0, 0, 0);
        step("R7", 1, 32'hFFFF_FFF5, 1, 0, 1, 1, 0);
        step("R7", 1, 32'hFFFF_FFF5, 1, 0, 0, 0, 0);
        // R6: same-cycle write uses old value, next cycle new
        step("R6", 1, 32'hFFFF_FFF5, 0, 0, 1, 1, 0);
        step("R6", 1, 32'hFFFF_FFF5, 1, 0, 0, 0, 0);
        step("R6", 1, 32'hFFFF_FFF5, 1, 0, 0, 0, 0);
        idle("R9");
        idle("R9");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule